// File: doc/BRIEF.md
# Master-Mode Bus Release Arbiter

This block decides who drives the external bus when the device is the default owner. Another master can ask for the bus with a request line. The bus sequencer reports through an in-cycle flag whether an access is under way. The arbiter lets the bus go only between accesses. It answers with an acknowledge and, while the bus is away, stops the sequencer from starting new accesses.

The hand-over is protected in both directions. Before the output enables of the bus control lines are removed, the arbiter spends one cycle driving those lines at their inactive level. When the other master withdraws its request, the acknowledge drops. In that same cycle the arbiter takes the lines back at their inactive level, and only one cycle later does it pass the sequencer's values through again. The two masters therefore never drive opposing levels on a shared line.

The control lines are active-low, so their inactive level is all ones. The external request passes through a synchronizer whose depth is set by a parameter. A depth of 0 means a direct, already-synchronous input.

Top module: `busown_arbiter`

## Requirements
- R1: During and after reset the block owns the bus: `ext_ack_o`=0, `ctrl_oe_o` all ones, `ctrl_o` equal to `ctrl_val_i`, `seq_ok_o`=1.
- R2: A request that is seen (after `REQ_SYNC` clocks of synchronization) while `cyc_active_i`=0 produces exactly one cycle with `ctrl_oe_o` all ones and `ctrl_o` all ones and `ext_ack_o`=0. On the next clock `ext_ack_o`=1 and `ctrl_oe_o`=0.
- R3: While `cyc_active_i`=1 the bus is never released, even with a request pending, and `ctrl_o` keeps following `ctrl_val_i`.
- R4: `seq_ok_o` is 1 only while the block owns the bus and no synchronized request is pending. It is never 1 together with `ext_ack_o`.
- R5: While released (`ext_ack_o`=1), `ctrl_oe_o` is all zeros and `ctrl_o` stays all ones whatever `ctrl_val_i` does.
- R6: When the synchronized request goes low while released, `ext_ack_o` falls on the same clock that `ctrl_oe_o` returns to all ones with `ctrl_o` all ones. One cycle later `ctrl_o` follows `ctrl_val_i` again and `seq_ok_o`=1.
- R7: A request withdrawn before an ongoing cycle ends never yields an acknowledge.
- R8: A request seen in an idle cycle always completes the release: once the inactive-drive cycle has started, the acknowledge is given for at least one cycle even if the request has already gone away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_i | input | 1 | Bus request from the other master, active high |
| cyc_active_i | input | 1 | High while the sequencer is inside a bus cycle |
| ctrl_val_i | input | N_CTRL | Control-line values the sequencer wants driven |
| seq_ok_o | output | 1 | Sequencer may start a new bus cycle |
| ext_ack_o | output | 1 | Bus acknowledge to the other master, active high |
| ctrl_oe_o | output | N_CTRL | Output enable per control line |
| ctrl_o | output | N_CTRL | Level driven on each control line |

## Verification
The hardest situations to reach are the races between the synchronized request and the state machine. In one, a request is withdrawn while a cycle is still holding it off. In the other, a one-clock request pulse lands in an idle cycle, so the release starts after the request is already gone. The stimulus table sets up both races by counting the synchronizer delay. It raises or drops the request a fixed number of clocks before the cycle flag falls, so the synchronized copy and the in-cycle flag meet on the exact edge that matters. Directed steps then apply reset in the middle of a release.

// File: rtl/busown_pkg.sv
package busown_pkg;

   typedef enum logic [1:0] {
      OWN_ST_OWNED      = 2'd0,
      OWN_ST_NEG_REL    = 2'd1,
      OWN_ST_RELEASED   = 2'd2,
      OWN_ST_NEG_REGAIN = 2'd3
   } own_state_e;

   localparam int unsigned MAX_SYNC_STAGES = 3;
   localparam int unsigned MAX_CTRL_LINES  = 64;

endpackage

// File: rtl/busown_req_sync.sv
module busown_req_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic req_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign req_o = req_i;
      end else begin : g_flops
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else if (STAGES == 1) begin
               chain_q[0] <= req_i;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], req_i};
            end
         end
         assign req_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/busown_fsm.sv
module busown_fsm
   import busown_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s_i,
   input  logic       cyc_active_i,
   output own_state_e state_o,
   output logic       seq_ok_o
);

   own_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         OWN_ST_OWNED:      if (req_s_i && !cyc_active_i) state_d = OWN_ST_NEG_REL;
         OWN_ST_NEG_REL:    state_d = OWN_ST_RELEASED;
         OWN_ST_RELEASED:   if (!req_s_i) state_d = OWN_ST_NEG_REGAIN;
         OWN_ST_NEG_REGAIN: state_d = OWN_ST_OWNED;
         default:           state_d = OWN_ST_OWNED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= OWN_ST_OWNED;
      else        state_q <= state_d;
   end

   assign state_o  = state_q;
   assign seq_ok_o = (state_q == OWN_ST_OWNED) && !req_s_i;

   // R3
   no_release_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == OWN_ST_OWNED && cyc_active_i) |=> (state_q == OWN_ST_OWNED));

   // R2
   neg_rel_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == OWN_ST_NEG_REL) |=> (state_q == OWN_ST_RELEASED));

   // R6
   neg_regain_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == OWN_ST_NEG_REGAIN) |=> (state_q == OWN_ST_OWNED));

endmodule

// File: rtl/busown_drive.sv
module busown_drive
   import busown_pkg::*;
#(
   parameter int unsigned       N_CTRL    = 4,
   parameter logic [N_CTRL-1:0] CTRL_IDLE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  own_state_e        state_i,
   input  logic [N_CTRL-1:0] val_i,
   output logic              ack_o,
   output logic [N_CTRL-1:0] oe_o,
   output logic [N_CTRL-1:0] ctrl_o
);

   logic pass_through;
   logic driving;

   assign pass_through = (state_i == OWN_ST_OWNED);
   assign driving      = (state_i != OWN_ST_RELEASED);
   assign ack_o        = (state_i == OWN_ST_RELEASED);

   generate
      for (genvar b = 0; b < N_CTRL; b++) begin : g_line
         assign oe_o[b]   = driving;
         assign ctrl_o[b] = pass_through ? val_i[b] : CTRL_IDLE[b];
      end
   endgenerate

   // R5
   released_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (oe_o == '0 && ctrl_o == CTRL_IDLE));

endmodule

// File: rtl/busown_arbiter.sv
module busown_arbiter
   import busown_pkg::*;
#(
   parameter int unsigned N_CTRL   = 4,
   parameter int unsigned REQ_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_req_i,
   input  logic              cyc_active_i,
   input  logic [N_CTRL-1:0] ctrl_val_i,
   output logic              seq_ok_o,
   output logic              ext_ack_o,
   output logic [N_CTRL-1:0] ctrl_oe_o,
   output logic [N_CTRL-1:0] ctrl_o
);

   localparam logic [N_CTRL-1:0] CTRL_IDLE = {N_CTRL{1'b1}};

   generate
      if (N_CTRL < 1 || N_CTRL > MAX_CTRL_LINES) begin : g_bad_width
         $error("busown_arbiter: N_CTRL out of range");
      end
      if (REQ_SYNC > MAX_SYNC_STAGES) begin : g_bad_sync
         $error("busown_arbiter: REQ_SYNC too deep");
      end
   endgenerate

   logic       req_s;
   own_state_e state;

   busown_req_sync #(.STAGES(REQ_SYNC)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (ext_req_i),
      .req_o (req_s)
   );

   busown_fsm fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_s_i      (req_s),
      .cyc_active_i (cyc_active_i),
      .state_o      (state),
      .seq_ok_o     (seq_ok_o)
   );

   busown_drive #(.N_CTRL(N_CTRL), .CTRL_IDLE(CTRL_IDLE)) drive_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (state),
      .val_i   (ctrl_val_i),
      .ack_o   (ext_ack_o),
      .oe_o    (ctrl_oe_o),
      .ctrl_o  (ctrl_o)
   );

   // R2
   negate_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_ack_o) |-> ($past(ctrl_oe_o) == CTRL_IDLE && $past(ctrl_o) == CTRL_IDLE));

   // R6
   negate_on_regain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_ack_o) |-> (ctrl_oe_o == CTRL_IDLE && ctrl_o == CTRL_IDLE));

   // R4
   no_start_when_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_ok_o |-> !ext_ack_o);

endmodule

// File: tb/busown_arbiter_tb.sv
module busown_arbiter_tb_top;

   localparam int unsigned N = 4;

   typedef struct packed {
      logic [3:0] tag;
      logic       req;
      logic       cyc;
      logic [3:0] val;
      logic       ack;
      logic       oe;
      logic [3:0] ctrl;
      logic       ok;
   } vec_t;

   // tag: requirement number; inputs req,cyc,val; expected ack,oe(all),ctrl,ok
   localparam vec_t TBL [22] = '{
      '{4'd1, 1'b0, 1'b0, 4'h5, 1'b0, 1'b1, 4'h5, 1'b1}, // R1 idle
      '{4'd3, 1'b1, 1'b1, 4'hA, 1'b0, 1'b1, 4'hA, 1'b1}, // R3 sync stage 1
      '{4'd4, 1'b1, 1'b1, 4'h3, 1'b0, 1'b1, 4'h3, 1'b0}, // R4 pending
      '{4'd3, 1'b1, 1'b1, 4'h6, 1'b0, 1'b1, 4'h6, 1'b0}, // R3 held
      '{4'd3, 1'b1, 1'b1, 4'h9, 1'b0, 1'b1, 4'h9, 1'b0}, // R3 held
      '{4'd2, 1'b1, 1'b0, 4'hC, 1'b0, 1'b1, 4'hF, 1'b0}, // R2 negate
      '{4'd2, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 4'hF, 1'b0}, // R2 released
      '{4'd5, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 4'hF, 1'b0}, // R5 ignored
      '{4'd5, 1'b0, 1'b0, 4'h2, 1'b1, 1'b0, 4'hF, 1'b0}, // R5
      '{4'd5, 1'b0, 1'b0, 4'h2, 1'b1, 1'b0, 4'hF, 1'b0}, // R5
      '{4'd6, 1'b0, 1'b0, 4'h2, 1'b0, 1'b1, 4'hF, 1'b0}, // R6 regain negate
      '{4'd6, 1'b0, 1'b0, 4'h2, 1'b0, 1'b1, 4'h2, 1'b1}, // R6 normal
      '{4'd7, 1'b1, 1'b1, 4'h7, 1'b0, 1'b1, 4'h7, 1'b1}, // R7
      '{4'd7, 1'b0, 1'b1, 4'h7, 1'b0, 1'b1, 4'h7, 1'b0}, // R7
      '{4'd7, 1'b0, 1'b1, 4'h7, 1'b0, 1'b1, 4'h7, 1'b1}, // R7 withdrawn
      '{4'd7, 1'b0, 1'b0, 4'h7, 1'b0, 1'b1, 4'h7, 1'b1}, // R7 no ack
      '{4'd8, 1'b1, 1'b0, 4'h1, 1'b0, 1'b1, 4'h1, 1'b1}, // R8 pulse
      '{4'd8, 1'b0, 1'b0, 4'h1, 1'b0, 1'b1, 4'h1, 1'b0}, // R8
      '{4'd8, 1'b0, 1'b0, 4'h1, 1'b0, 1'b1, 4'hF, 1'b0}, // R8 negate
      '{4'd8, 1'b0, 1'b0, 4'h1, 1'b1, 1'b0, 4'hF, 1'b0}, // R8 ack given
      '{4'd8, 1'b0, 1'b0, 4'h1, 1'b0, 1'b1, 4'hF, 1'b0}, // R8 regain
      '{4'd8, 1'b0, 1'b0, 4'h1, 1'b0, 1'b1, 4'h1, 1'b1}  // R8 owned
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ext_req = 1'b0;
   logic         cyc_active = 1'b0;
   logic [N-1:0] ctrl_val = 4'h5;
   logic         seq_ok, ext_ack;
   logic [N-1:0] ctrl_oe, ctrl;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   busown_arbiter #(.N_CTRL(N), .REQ_SYNC(2)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_req_i    (ext_req),
      .cyc_active_i (cyc_active),
      .ctrl_val_i   (ctrl_val),
      .seq_ok_o     (seq_ok),
      .ext_ack_o    (ext_ack),
      .ctrl_oe_o    (ctrl_oe),
      .ctrl_o       (ctrl)
   );

   task automatic check(input int tag, input logic ack_e, input logic [N-1:0] oe_e,
                        input logic [N-1:0] ctrl_e, input logic ok_e);
      tests++;
      if (ext_ack !== ack_e || ctrl_oe !== oe_e || ctrl !== ctrl_e || seq_ok !== ok_e) begin
         fails++;
         $display("FAIL R%0d: ack=%b oe=%h ctrl=%h ok=%b expected ack=%b oe=%h ctrl=%h ok=%b",
                  tag, ext_ack, ctrl_oe, ctrl, seq_ok, ack_e, oe_e, ctrl_e, ok_e);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(1, 1'b0, 4'hF, 4'h5, 1'b1);      // R1 during reset
      ctrl_val = 4'h9;
      #1;
      check(1, 1'b0, 4'hF, 4'h9, 1'b1);      // R1 pass-through in reset
      rst_n = 1'b1;
      @(posedge clk); #1;

      foreach (TBL[i]) begin
         ext_req    = TBL[i].req;
         cyc_active = TBL[i].cyc;
         ctrl_val   = TBL[i].val;
         @(posedge clk); #1;
         check(int'(TBL[i].tag), TBL[i].ack, {N{TBL[i].oe}}, TBL[i].ctrl, TBL[i].ok);
      end

      // R1: reset in the middle of a release returns ownership at once
      ext_req = 1'b1; cyc_active = 1'b0; ctrl_val = 4'h4;
      repeat (4) @(posedge clk);
      #1;
      check(5, 1'b1, 4'h0, 4'hF, 1'b0);      // R5 released before reset
      rst_n = 1'b0;
      #1;
      check(1, 1'b0, 4'hF, 4'h4, 1'b1);      // R1 async reset
      ext_req = 1'b0;
      @(posedge clk); #1;
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check(1, 1'b0, 4'hF, 4'h4, 1'b1);      // R1 stays owned

      // R3: a long cycle holds a request off for many clocks
      ext_req = 1'b1; cyc_active = 1'b1;
      for (int k = 0; k < 10; k++) begin
         ctrl_val = 4'(k);
         @(posedge clk); #1;
         check(3, 1'b0, 4'hF, 4'(k), (k < 1) ? 1'b1 : 1'b0);
      end
      cyc_active = 1'b0;
      @(posedge clk); #1;
      check(2, 1'b0, 4'hF, 4'hF, 1'b0);      // R2 negate cycle
      @(posedge clk); #1;
      check(2, 1'b1, 4'h0, 4'hF, 1'b0);      // R2 ack
      ext_req = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check(6, 1'b0, 4'hF, 4'hF, 1'b0);      // R6 regain negate
      @(posedge clk); #1;
      check(6, 1'b0, 4'hF, 4'(9), 1'b1);     // R6 normal drive

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule